// File: doc/BRIEF.md
# Line-Delay FIFO with Pointer Resets

This block is a single-clock sequential memory of the line-delay kind. It holds 5120 words of 8 bits. A write pointer and a read pointer step through the array independently, so a read stream can trail a write stream by any fixed number of clocks, for example one video line. Neither side has a full or an empty flag, and the writer may overrun data that has not yet been read.

Each pointer has its own active-low pointer-reset input, which is sampled on the rising clock edge. A reset sampled on the same edge as an access makes that access use address 0. A reset sampled with no access on that side makes the next access on that side use address 0, however many idle edges come between. A pointer has no defined value until its first reset. The read word is registered, and a combinational output enable forces the output to zero while it is high.

Top module: `linedelay_fifo`

## Requirements
- R1: On each rising edge with `we_n` low and `wrst_n` high, `din` is stored at the write pointer, and the pointer then advances by one.
- R2: On each rising edge with `re_n` low, the word at the read address is registered. It appears on `dout` (with `oe_n` low) after that edge and stays there until the next read edge.
- R3: When `wrst_n` and `we_n` are both low on the same edge, the word is written to address 0 and the next write goes to address 1.
- R4: A `wrst_n` low pulse of a single edge with `we_n` high makes the next write, after any number of idle edges, go to address 0.
- R5: When `rrst_n` and `re_n` are both low on the same edge, the word at address 0 is read and the next read uses address 1.
- R6: A `rrst_n` low pulse of a single edge with `re_n` high makes the next read, after any number of idle edges, use address 0.
- R7: Both pointers wrap from address 5119 to address 0 with no gap.
- R8: While `oe_n` is high, `dout` is 0 in the same cycle. The enable has no effect on the stored data or on the pointers.
- R9: The pointers are independent, with no overflow protection: a write overwrites unread data. A read and a write to the same address on one edge return the old word.
- R10: An edge with `re_n` and `rrst_n` high leaves `dout` unchanged. An edge with `we_n` and `wrst_n` high leaves the write pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state |
| din | input | 8 | Write data |
| we_n | input | 1 | Write enable, active low |
| re_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low; a high value forces `dout` to 0 |
| wrst_n | input | 1 | Write pointer reset, active low, sampled on the edge |
| rrst_n | input | 1 | Read pointer reset, active low, sampled on the edge |
| dout | output | 8 | Registered read data, gated by `oe_n` |

## Verification
A write pointer that slips or misses a reset does not show at once. The error appears only when that location is read back, so it reaches `dout` one clock after the read edge that fetches the misplaced word, which may be a full wrap later. A read pointer error shows on the first read edge after it occurs. For this reason the reference model compares `dout` after every edge, and the full-wrap run reads every address once. Checks on the pointers themselves catch step and reset faults on the edge after they happen, before any data is read back.

// File: rtl/linedelay_fifo.sv
module linedelay_fifo #(
  parameter int DEPTH = 5120,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  input  logic             we_n,
  input  logic             re_n,
  input  logic             oe_n,
  input  logic             wrst_n,
  input  logic             rrst_n,
  output logic [WIDTH-1:0] dout
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW-1:0]    wsel, rsel;
  logic [WIDTH-1:0] rdata;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + AW'(1);
  endfunction

  assign wsel = wrst_n ? wptr : '0;
  assign rsel = rrst_n ? rptr : '0;

  always_ff @(posedge clk) begin
    if (!we_n) begin
      mem[wsel] <= din;
      wptr      <= bump(wsel);
    end else if (!wrst_n) begin
      wptr <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!re_n) begin
      rdata <= mem[rsel];
      rptr  <= bump(rsel);
    end else if (!rrst_n) begin
      rptr <= '0;
    end
  end

  assign dout = oe_n ? '0 : rdata;
endmodule

module linedelay_fifo_chk #(
  parameter int DEPTH = 5120,
  parameter int WIDTH = 8
) (
  input logic                     clk,
  input logic                     we_n,
  input logic                     re_n,
  input logic                     oe_n,
  input logic                     wrst_n,
  input logic                     rrst_n,
  input logic [WIDTH-1:0]         dout,
  input logic [$clog2(DEPTH)-1:0] wptr,
  input logic [$clog2(DEPTH)-1:0] rptr
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic w_ok = 1'b0;
  logic r_ok = 1'b0;
  always_ff @(posedge clk) begin
    if (!wrst_n) w_ok <= 1'b1;
    if (!rrst_n) r_ok <= 1'b1;
  end

  p_wstep_r1: assert property (@(posedge clk) disable iff (!w_ok)
    (!we_n && wrst_n) |=> (wptr == $past(wptr) + AW'(1)) || (wptr == '0 && $past(wptr) == LAST));
  p_rstep_r2: assert property (@(posedge clk) disable iff (!r_ok)
    (!re_n && rrst_n) |=> (rptr == $past(rptr) + AW'(1)) || (rptr == '0 && $past(rptr) == LAST));
  p_wrst_hit_r3: assert property (@(posedge clk) disable iff (!w_ok)
    (!we_n && !wrst_n) |=> wptr == AW'(1));
  p_wrst_idle_r4: assert property (@(posedge clk) disable iff (!w_ok)
    (we_n && !wrst_n) |=> wptr == '0);
  p_rrst_hit_r5: assert property (@(posedge clk) disable iff (!r_ok)
    (!re_n && !rrst_n) |=> rptr == AW'(1));
  p_rrst_idle_r6: assert property (@(posedge clk) disable iff (!r_ok)
    (re_n && !rrst_n) |=> rptr == '0);
  p_range_r7: assert property (@(posedge clk) disable iff (!(w_ok && r_ok))
    (int'(wptr) < DEPTH) && (int'(rptr) < DEPTH));
  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!r_ok)
    oe_n |-> dout == '0);
  p_hold_r10: assert property (@(posedge clk) disable iff (!r_ok)
    (re_n && rrst_n && !oe_n) |=> (oe_n || $stable(dout)));
  p_wfreeze_r10: assert property (@(posedge clk) disable iff (!w_ok)
    (we_n && wrst_n) |=> $stable(wptr));
endmodule

bind linedelay_fifo linedelay_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .we_n(we_n), .re_n(re_n), .oe_n(oe_n), .wrst_n(wrst_n),
  .rrst_n(rrst_n), .dout(dout), .wptr(wptr), .rptr(rptr)
);

// File: tb/linedelay_fifo_tb.sv
`timescale 1ns/1ps
module linedelay_fifo_tb;
  localparam int DEPTH = 5120;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic we_n = 1'b1, re_n = 1'b1, oe_n = 1'b1, wrst_n = 1'b1, rrst_n = 1'b1;
  logic [WIDTH-1:0] dout;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int m [DEPTH];
  int wp = 0, rp = 0, rd = -1;

  always #10 clk = ~clk;

  linedelay_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .din(din), .we_n(we_n), .re_n(re_n), .oe_n(oe_n),
    .wrst_n(wrst_n), .rrst_n(rrst_n), .dout(dout)
  );

  task automatic check(input string tag, input int expv);
    total++;
    if (int'(dout) != expv) begin
      bad++;
      $display("FAIL %s: dout=%0d expected=%0d at %0t", tag, dout, expv, $time);
    end
  endtask

  task automatic step(input bit we, input bit re, input bit oe, input bit wr,
                      input bit rr, input int d, input string tag);
    int ra, wa;
    we_n = we; re_n = re; oe_n = oe; wrst_n = wr; rrst_n = rr; din = WIDTH'(d);
    @(posedge clk);
    if (!re) begin
      ra = rr ? rp : 0;
      rd = m[ra];
      rp = (ra + 1) % DEPTH;
    end else if (!rr) rp = 0;
    if (!we) begin
      wa = wr ? wp : 0;
      m[wa] = d & 255;
      wp = (wa + 1) % DEPTH;
    end else if (!wr) wp = 0;
    @(negedge clk);
    if (oe) check(tag, 0);
    else if (rd >= 0) check(tag, rd);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m[i] = -1;
    repeat (2) @(negedge clk);

    // reset state: both pointers reset, output disabled -> 0 (R8)
    step(1, 1, 1, 0, 0, 0, "R8 reset-state");

    // R1: plain writes
    for (int i = 0; i < 10; i++) step(0, 1, 0, 1, 1, 16 + i * 3, "R1 write");
    // R5: read coincident with read reset returns address 0
    step(1, 0, 0, 1, 0, 0, "R5 read+reset");
    // R2: subsequent reads
    for (int i = 0; i < 9; i++) step(1, 0, 0, 1, 1, 0, "R2 read");
    // R10: idle edges hold dout
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 1, 0, "R10 idle hold");

    // R4: one-edge write reset without write, idle, then writes land at 0
    step(1, 1, 0, 0, 1, 0, "R4 wreset pulse");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 1, 0, "R4 idle");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 1, 1, 200 + i, "R4 write after reset");
    // R6: one-edge read reset, idle, then reads start at 0
    step(1, 1, 0, 1, 0, 0, "R6 rreset pulse");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 1, 0, "R6 idle");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 1, 0, "R6 read after reset");

    // R3: write coincident with write reset
    step(0, 1, 0, 0, 1, 77, "R3 write+reset");
    step(0, 1, 0, 1, 1, 78, "R3 next write");
    step(1, 0, 0, 1, 0, 0, "R3 read back addr0");
    step(1, 0, 0, 1, 1, 0, "R3 read back addr1");

    // R8: output enable gating mid-cycle, no effect on data
    #2 oe_n = 1'b1; #1 check("R8 oe high", 0);
    #2 oe_n = 1'b0; #1 check("R8 oe low", rd);
    step(1, 1, 1, 1, 1, 0, "R8 oe high edge");
    step(1, 0, 0, 1, 1, 0, "R8 read after oe");

    // R9: same-address read and write on one edge returns old word
    step(0, 0, 0, 0, 0, 170, "R9 same addr");
    step(1, 0, 0, 1, 0, 0, "R9 new word at 0");

    // R7/R9: full wrap with overwrite on both pointers
    step(0, 1, 0, 0, 1, 1, "R7 wrap start");
    for (int i = 1; i < DEPTH + 6; i++) step(0, 1, 0, 1, 1, (i * 7 + 3), "R7 write wrap");
    step(1, 0, 0, 1, 0, 0, "R7 read wrap start");
    for (int i = 1; i < DEPTH + 6; i++) step(1, 0, 0, 1, 1, 0, "R7 read wrap");

    // R9: interleaved writer ahead of reader
    for (int i = 0; i < 20; i++) step(i % 3 == 0, i % 2 == 0, 0, 1, 1, 90 + i, "R9 interleave");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3ms;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: timeout actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule